// File: doc/BRIEF.md
# Tuner Configuration Register Slave on a Two-Wire Bus

This block is the control front end of a tuner: a slave on a two-wire serial bus (I2C-compatible) that owns the tuner's bank of configuration registers. It samples SCL and SDA with a fast system clock and detects START, repeated START and STOP. It answers at one of two 7-bit addresses, chosen by a strap pin. It drives SDA only through an open-drain output enable.

A host writes by sending the device address, a register pointer and any number of data bytes. The pointer steps forward after every byte. To read, the host writes the pointer, issues a repeated START and reads as many bytes as it wants. Reads and writes use the same pointer. Twelve configuration registers are writable and come out of reset at fixed defaults. Two status registers are read-only. The first status register carries a sticky power-on flag. Writing the low byte of the synthesizer divider fires a one-cycle pulse that starts the oscillator-band search.

Top module: `tuner_cfg_i2c`

## Requirements
- R1: The device address is 1100000 when `addr_sel` is 0 and 1100001 when it is 1, so the address bytes are 0xC0/0xC1 or 0xC2/0xC3. A matching address byte is acknowledged by driving SDA low through the ninth clock.
- R2: An address byte that does not match is not acknowledged. The slave then leaves SDA released and ignores every byte until the next START, so the data bytes that follow change no register.
- R3: In a write, the byte after the address is the pointer, of which only bits 3:0 are used. Each data byte is acknowledged, stored at the pointer and sent out on `cfg_o` (register k at bits 8k+7:8k), and the pointer then advances by one.
- R4: Reset loads the defaults 0x00=0x03, 0x01=0xB6 (divider 950), 0x02=0x00, 0x03=0x00, 0x04=0x00, 0x05=0x04, 0x06=0xC0, 0x07=0xCC, 0x08=0x4B, 0x09=0x00, 0x0A=0x00 and 0x0B=0x00. After reset SDA is released.
- R5: After a pointer write, a repeated START and the read address, the slave shifts out the register at the pointer MSB first. It continues with the next register for as long as the master acknowledges, and stops driving after a master NACK.
- R6: The pointer advances from 0x0D (and from the unused values 0x0E and 0x0F) to 0x00. Reads at 0x0E and 0x0F return 0x00.
- R7: Addresses 0x0C and 0x0D are read-only. Writes to them are acknowledged and discarded. 0x0C bits 6:0 read `stat_a_i`, and 0x0D reads `stat_b_i`.
- R8: Bit 7 of 0x0C is 1 after reset. It clears only once 0x0C has been read in a transaction that has since ended with STOP. A repeated START does not end the transaction.
- R9: `tune_o` is high for exactly one cycle after each byte written to 0x01. Writes to other registers raise no pulse.
- R10: A falling SDA while SCL is high is a START and restarts address reception. A rising SDA while SCL is high is a STOP and returns the slave to idle with SDA released. The slave changes SDA only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset (power-on) |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| addr_sel | input | 1 | Address strap, becomes the address LSB |
| stat_a_i | input | 7 | Status flags shown in bits 6:0 of register 0x0C |
| stat_b_i | input | 8 | Status byte shown in register 0x0D |
| cfg_o | output | 96 | The twelve configuration registers, register k at bits 8k+7:8k |
| tune_o | output | 1 | One-cycle pulse after a write to register 0x01 |

## Verification
The bus inputs pass through a two-flop synchronizer and an edge register before the controller acts, so SDA changes about four system clocks after the SCL edge that causes them. The bench sets its data while SCL is low and samples the line in the middle of the SCL-high phase, many cycles after any such change. A written register appears on `cfg_o` and the tune pulse fires one cycle after the falling SCL edge that ends the data byte is detected. The bench therefore checks `cfg_o` and the pulse count only after STOP, once several idle cycles have passed. The power-on flag clears one cycle after STOP is detected, and the bench observes it through the next read transaction.

// File: rtl/tcfg_pkg.sv
package tcfg_pkg;

  localparam int REG_W      = 8;
  localparam int PTR_W      = 4;
  localparam int CFG_COUNT  = 12;
  localparam int STAT_A_IDX = CFG_COUNT;
  localparam int STAT_B_IDX = CFG_COUNT + 1;
  localparam int LAST_IDX   = STAT_B_IDX;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK,
    ST_IGNORE
  } bus_st_t;

  // reset value of each writable register
  function automatic logic [REG_W-1:0] cfg_default(input int idx);
    case (idx)
      0:       return 8'h03;   // divider high bits (950 = 0x3B6)
      1:       return 8'hB6;   // divider low byte
      5:       return 8'h04;   // reference divide 4, crystal out divide 1
      6:       return 8'hC0;   // LO divide 4, current set by search
      7:       return 8'hCC;   // band 11001, search enabled
      8:       return 8'h4B;   // filter corner
      default: return 8'h00;
    endcase
  endfunction

  // pointer step with wrap after the last status register
  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    if (p >= PTR_W'(LAST_IDX)) return '0;
    return p + 1'b1;
  endfunction

  // address derived from the base and the strap
  function automatic logic [6:0] dev_addr(input logic [6:0] base, input logic sel);
    return {base[6:1], base[0] | sel};
  endfunction

endpackage

// File: rtl/tcfg_bus_sync.sv
module tcfg_bus_sync #(
  parameter int SYNC_LEN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [SYNC_LEN-1:0] scl_sh, sda_sh;
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_LEN-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC_LEN-2:0], sda_i};
      scl_p  <= scl_s;
      sda_p  <= sda_s;
    end
  end

  assign scl_s     = scl_sh[SYNC_LEN-1];
  assign sda_s     = sda_sh[SYNC_LEN-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/tcfg_regbank.sv
module tcfg_regbank
  import tcfg_pkg::*;
#(
  parameter int NUM_CFG  = CFG_COUNT,
  parameter int TUNE_IDX = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_stb,
  input  logic [PTR_W-1:0]         wr_addr,
  input  logic [REG_W-1:0]         wr_data,
  input  logic [PTR_W-1:0]         rd_addr,
  output logic [REG_W-1:0]         rd_data,
  input  logic [6:0]               stat_a,
  input  logic [REG_W-1:0]         stat_b,
  input  logic                     por_clr,
  output logic                     por_flag,
  output logic                     tune_pulse,
  output logic [NUM_CFG*REG_W-1:0] cfg_flat
);

  logic [REG_W-1:0] regs [NUM_CFG];

  for (genvar i = 0; i < NUM_CFG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              regs[i] <= cfg_default(i);
      else if (wr_stb && wr_addr == PTR_W'(i)) regs[i] <= wr_data;
    end
    assign cfg_flat[i*REG_W +: REG_W] = regs[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      por_flag   <= 1'b1;
      tune_pulse <= 1'b0;
    end else begin
      if (por_clr) por_flag <= 1'b0;
      tune_pulse <= wr_stb && (wr_addr == PTR_W'(TUNE_IDX));
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr < PTR_W'(NUM_CFG))            rd_data = regs[rd_addr];
    else if (rd_addr == PTR_W'(STAT_A_IDX))   rd_data = {por_flag, stat_a};
    else if (rd_addr == PTR_W'(STAT_B_IDX))   rd_data = stat_b;
  end

  AST_POR_NEVER_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(por_flag));                                                    // R8
  AST_TUNE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    tune_pulse |=> !tune_pulse);                                          // R9
  AST_TUNE_CARRIES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    tune_pulse |-> regs[TUNE_IDX] == $past(wr_data));                     // R9
  AST_CFG_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_flat) |-> $past(wr_stb));                                // R3

endmodule

// File: rtl/tuner_cfg_i2c.sv
module tuner_cfg_i2c
  import tcfg_pkg::*;
#(
  parameter logic [6:0] BASE_ADDR = 7'b1100000,
  parameter int         SYNC_LEN  = 2,
  parameter int         NUM_CFG   = CFG_COUNT,
  parameter int         TUNE_IDX  = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     scl_i,
  input  logic                     sda_i,
  output logic                     sda_oe,
  input  logic                     addr_sel,
  input  logic [6:0]               stat_a_i,
  input  logic [REG_W-1:0]         stat_b_i,
  output logic [NUM_CFG*REG_W-1:0] cfg_o,
  output logic                     tune_o
);

  localparam int CNT_W = 4;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  tcfg_bus_sync #(.SYNC_LEN(SYNC_LEN)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  bus_st_t          st;
  logic [CNT_W-1:0] cnt;
  logic [REG_W-1:0] rx_sh, tx_sh, rd_data;
  logic [PTR_W-1:0] ptr;
  logic             oe_q, rnw, m_nack, stat_seen, por_flag;

  // named internal events
  logic byte_done, addr_hit, wr_stb, por_clr;
  assign byte_done = scl_fall && (cnt == CNT_W'(8));
  assign addr_hit  = rx_sh[7:1] == dev_addr(BASE_ADDR, addr_sel);
  assign wr_stb    = (st == ST_WDATA) && byte_done;
  assign por_clr   = stop_det && stat_seen;

  tcfg_regbank #(.NUM_CFG(NUM_CFG), .TUNE_IDX(TUNE_IDX)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_stb     (wr_stb),
    .wr_addr    (ptr),
    .wr_data    (rx_sh),
    .rd_addr    (ptr),
    .rd_data    (rd_data),
    .stat_a     (stat_a_i),
    .stat_b     (stat_b_i),
    .por_clr    (por_clr),
    .por_flag   (por_flag),
    .tune_pulse (tune_o),
    .cfg_flat   (cfg_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      ptr       <= '0;
      oe_q      <= 1'b0;
      rnw       <= 1'b0;
      m_nack    <= 1'b0;
      stat_seen <= 1'b0;
    end else if (start_det) begin
      st   <= ST_ADDR;
      cnt  <= '0;
      oe_q <= 1'b0;
    end else if (stop_det) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      oe_q      <= 1'b0;
      stat_seen <= 1'b0;
    end else begin
      case (st)
        ST_ADDR, ST_PTR, ST_WDATA: begin
          if (scl_rise && cnt < CNT_W'(8)) begin
            rx_sh <= {rx_sh[6:0], sda_s};
            cnt   <= cnt + 1'b1;
          end else if (byte_done) begin
            cnt <= '0;
            if (st == ST_ADDR) begin
              if (addr_hit) begin
                oe_q <= 1'b1;
                rnw  <= rx_sh[0];
                st   <= ST_ADDR_ACK;
              end else begin
                st <= ST_IGNORE;
              end
            end else if (st == ST_PTR) begin
              ptr  <= rx_sh[PTR_W-1:0];
              oe_q <= 1'b1;
              st   <= ST_PTR_ACK;
            end else begin
              ptr  <= ptr_next(ptr);
              oe_q <= 1'b1;
              st   <= ST_WDATA_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            if (rnw) begin
              tx_sh <= rd_data;
              oe_q  <= ~rd_data[7];
              ptr   <= ptr_next(ptr);
              if (ptr == PTR_W'(STAT_A_IDX)) stat_seen <= 1'b1;
              st    <= ST_RDATA;
            end else begin
              oe_q <= 1'b0;
              st   <= ST_PTR;
            end
          end
        end
        ST_PTR_ACK, ST_WDATA_ACK: begin
          if (scl_fall) begin
            oe_q <= 1'b0;
            st   <= ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (cnt == CNT_W'(7)) begin
              oe_q <= 1'b0;
              cnt  <= '0;
              st   <= ST_RACK;
            end else begin
              tx_sh <= {tx_sh[6:0], 1'b0};
              oe_q  <= ~tx_sh[6];
              cnt   <= cnt + 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            m_nack <= sda_s;
          end else if (scl_fall) begin
            if (!m_nack) begin
              tx_sh <= rd_data;
              oe_q  <= ~rd_data[7];
              ptr   <= ptr_next(ptr);
              if (ptr == PTR_W'(STAT_A_IDX)) stat_seen <= 1'b1;
              st    <= ST_RDATA;
            end else begin
              st <= ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe = oe_q;

  AST_QUIET_WHEN_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE || st == ST_IGNORE) |-> !sda_oe);                      // R2
  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(start_det) && !$past(stop_det)) |-> !$past(scl_s)); // R10
  AST_POR_CLEARS_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(por_flag) |-> $past(stop_det));                                 // R8
  AST_WRITE_IN_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> !scl_s);                                                   // R3

endmodule

// File: tb/tb_tuner_cfg_i2c.sv
module tb_tuner_cfg_i2c;

  localparam int Q = 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        addr_sel = 1'b0;
  logic [6:0]  stat_a = 7'h35;
  logic [7:0]  stat_b = 8'hA7;
  logic        sda_oe, tune_o;
  logic [95:0] cfg_o;
  wire         sda_line = sda_m & ~sda_oe;

  tuner_cfg_i2c dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_m),
    .sda_i    (sda_line),
    .sda_oe   (sda_oe),
    .addr_sel (addr_sel),
    .stat_a_i (stat_a),
    .stat_b_i (stat_b),
    .cfg_o    (cfg_o),
    .tune_o   (tune_o)
  );

  int n_cmp = 0, n_bad = 0;
  int tune_seen = 0, tune_exp = 0;
  logic tune_prev = 1'b0, tune_wide = 1'b0;
  logic [7:0] exp_regs [0:11];
  logic       por_exp;
  logic [7:0] wbuf [0:15];

  always @(posedge clk) begin
    if (rst_n) begin
      if (tune_o) tune_seen <= tune_seen + 1;
      if (tune_o && tune_prev) tune_wide <= 1'b1;
      tune_prev <= tune_o;
    end
  end

  function automatic logic [7:0] bench_default(input int i);
    logic [7:0] t [0:11];
    t = '{8'h03, 8'hB6, 8'h00, 8'h00, 8'h00, 8'h04, 8'hC0, 8'hCC, 8'h4B, 8'h00, 8'h00, 8'h00};
    return t[i];
  endfunction

  function automatic int step_ptr(input int p);
    return (p >= 13) ? 0 : p + 1;
  endfunction

  function automatic logic [7:0] exp_read(input int a);
    if (a < 12)  return exp_regs[a];
    if (a == 12) return {por_exp, stat_a};
    if (a == 13) return stat_b;
    return 8'h00;
  endfunction

  function automatic logic [95:0] exp_flat();
    logic [95:0] f;
    for (int i = 0; i < 12; i++) f[i*8 +: 8] = exp_regs[i];
    return f;
  endfunction

  task automatic chk(input string tag, input logic [95:0] got, input logic [95:0] want);
    n_cmp++;
    if (got !== want) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, want);
    end
  endtask

  task automatic hold();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hold();
    scl_m = 1'b1; hold();
    sda_m = 1'b0; hold();
    scl_m = 1'b0; hold();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold();
    scl_m = 1'b1; hold();
    sda_m = 1'b1; hold();
    hold();
  endtask

  task automatic bus_bit(input logic b, output logic r);
    sda_m = b;    hold();
    scl_m = 1'b1; hold();
    r = sda_line; hold();
    scl_m = 1'b0; hold();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], r);
    bus_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    logic r;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      bus_bit(1'b1, r);
      b = {b[6:0], r};
    end
    bus_bit(~mack, r);
  endtask

  function automatic logic [6:0] my_addr();
    return {6'b110000, addr_sel};
  endfunction

  // write n bytes from wbuf at ptr; ok says whether the address should match
  task automatic write_txn(input logic [6:0] dev, input int ptr, input int n, input bit ok);
    logic a;
    int p;
    bus_start();
    send_byte({dev, 1'b0}, a);
    chk(ok ? "R1 address ack" : "R2 address nack", 96'(a), 96'(ok));
    send_byte(8'(ptr), a);
    chk(ok ? "R3 pointer ack" : "R2 pointer ignored", 96'(a), 96'(ok));
    p = ptr;
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], a);
      if (!ok)       chk("R2 data ignored", 96'(a), 96'd0);
      else if (p > 11) chk("R7 read-only write acked", 96'(a), 96'd1);
      else           chk("R3 data ack", 96'(a), 96'd1);
      if (ok) begin
        if (p < 12) exp_regs[p] = wbuf[k];
        if (p == 1) tune_exp++;
        p = step_ptr(p);
      end
    end
    bus_stop();
    repeat (4) @(negedge clk);
    chk("R3 cfg_o after write", cfg_o, exp_flat());
    chk("R9 tune pulse count", 96'(tune_seen), 96'(tune_exp));
    chk("R9 tune pulse width", 96'(tune_wide), 96'd0);
    chk("R10 SDA released after STOP", 96'(sda_oe), 96'd0);
  endtask

  task automatic read_txn(input int ptr, input int n);
    logic a;
    logic [7:0] b;
    int p;
    bit saw = 0;
    bus_start();
    send_byte({my_addr(), 1'b0}, a);
    send_byte(8'(ptr), a);
    bus_start();
    send_byte({my_addr(), 1'b1}, a);
    chk("R5 read address ack", 96'(a), 96'd1);
    p = ptr;
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, b);
      if (p > 13)      chk("R6 unused pointer reads zero", 96'(b), 96'(exp_read(p)));
      else if (p > 11) chk("R7 status read", 96'(b), 96'(exp_read(p)));
      else             chk("R5 read data", 96'(b), 96'(exp_read(p)));
      if (p == 12) saw = 1;
      p = step_ptr(p);
    end
    chk("R5 released after nack", 96'(sda_oe), 96'd0);
    bus_stop();
    if (saw) por_exp = 1'b0;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad);
    $finish;
  end

  initial begin : main
    logic a;
    logic [7:0] b;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 12; i++) exp_regs[i] = bench_default(i);
    por_exp = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R4: reset state
    chk("R4 defaults on cfg_o", cfg_o, exp_flat());
    chk("R4 SDA released", 96'(sda_oe), 96'd0);
    chk("R9 no pulse at reset", 96'(tune_o), 96'd0);

    // R8: status read across a repeated START keeps the flag set
    read_txn(11, 1);                       // non-status read with STOP: flag stays
    bus_start();
    send_byte({my_addr(), 1'b0}, a);
    send_byte(8'd12, a);
    bus_start();
    send_byte({my_addr(), 1'b1}, a);
    recv_byte(1'b0, b);
    chk("R8 flag set after reset", 96'(b), 96'({1'b1, stat_a}));
    bus_start();
    send_byte({my_addr(), 1'b0}, a);
    send_byte(8'd12, a);
    bus_start();
    send_byte({my_addr(), 1'b1}, a);
    recv_byte(1'b0, b);
    chk("R8 flag held across repeated START", 96'(b), 96'({1'b1, stat_a}));
    bus_stop();
    por_exp = 1'b0;
    read_txn(12, 2);
    read_txn(12, 1);

    // R1 / R2: strap 0
    wbuf[0] = 8'h5A;
    write_txn(7'h61, 3, 1, 0);
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    write_txn(7'h60, 0, 3, 1);             // crosses 0x01: one pulse
    wbuf[0] = 8'h9C;
    write_txn(7'h60, 2, 1, 1);             // no pulse
    read_txn(0, 4);

    // R6 / R7: wrap and read-only writes
    wbuf[0] = 8'hE1; wbuf[1] = 8'hFF; wbuf[2] = 8'hFF; wbuf[3] = 8'h77;
    write_txn(7'h60, 11, 4, 1);
    read_txn(13, 3);
    read_txn(14, 3);
    wbuf[0] = 8'h42;
    write_txn(7'h60, 15, 1, 1);            // lands nowhere, pointer wraps

    // R1: strap 1
    addr_sel = 1'b1;
    repeat (4) @(negedge clk);
    wbuf[0] = 8'h66;
    write_txn(7'h60, 9, 1, 0);
    write_txn(7'h61, 9, 1, 1);
    read_txn(8, 3);
    addr_sel = 1'b0;
    repeat (4) @(negedge clk);

    // random traffic
    for (int it = 0; it < 10; it++) begin
      int s, n;
      s = $urandom % 14;
      n = 1 + ($urandom % 5);
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      write_txn(7'h60, s, n, 1);
      read_txn(s, n);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule